// File: doc/BRIEF.md
# Audio Channel and Width Converter

This block sits in a receive path between an audio-side sample stream and a client-side frame stream. Audio samples arrive one word per beat on a valid/ready handshake and are held in a 64-word FIFO. Once a complete audio frame (one word for mono, two for stereo) is buffered, the block converts it and offers it as one client frame per beat on a second valid/ready handshake.

Two conversions are applied to each frame. The width conversion turns a 16-bit audio sample into a 16-bit client sample, sign-extended into a 24-bit field, or a 32-bit audio sample into a 24-bit client sample. The channel conversion maps a mono frame to stereo, either by zero-filling or by copying the sample, and maps a stereo frame to mono by taking either channel or their average. When the audio and client channel counts match, only the width conversion is applied.

A threshold flag reports whether the number of whole buffered frames has reached a programmed frame count. The maximum usable threshold depends on the audio channel count, and larger requests are clamped to that maximum. Configuration inputs are expected to change only while the FIFO is empty.

Top module: `audio_chan_width_conv`

## Requirements
- R1: After reset the FIFO is empty: `inReady` is 1 and `outValid` is 0.
- R2: The FIFO holds 64 words. `inReady` is 0 exactly while 64 words are stored, and a word is stored only on a cycle with `inValid` and `inReady` both high. A word offered while full is dropped and never appears at the output.
- R3: `outValid` is 1 exactly when at least one whole audio frame is stored (2 words when `cfgAudioStereo`=1, 1 word otherwise). A frame is consumed on a cycle with `outValid` and `outReady` both high. A push and a pop in the same cycle are both honoured.
- R4: Width: with `cfgWide`=0 an audio sample is `inData[15:0]`, and the client value is that sample sign-extended to 24 bits. With `cfgWide`=1 the client value is `inData[31:8]`.
- R5: With mono audio (`cfgAudioStereo`=0) and a stereo client (`cfgClientStereo`=1), `outLeft` carries the sample. `outRight` is 0 when `cfgMonoCopy`=0 (the reset default) and equals `outLeft` when `cfgMonoCopy`=1.
- R6: With stereo audio and a mono client, `outLeft` is the first word of the frame when `cfgStereoSel`=0, the second word when it is 1, and floor((first+second)/2) of the signed 24-bit values when it is 2 or 3. `outRight` is 0.
- R7: When the channel counts are equal, the samples pass through with only the width conversion. Stereo gives left = first word and right = second word. Mono gives left = the sample and right = 0.
- R8: `threshHit` is 1 exactly when the number of whole buffered frames is at least min(`cfgThresh`, 64/channels − 1), that is, a limit of 63 for mono audio and 31 for stereo audio.
- R9: Frames leave in the order their words arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgAudioStereo | input | 1 | Audio side carries 2 channels per frame |
| cfgClientStereo | input | 1 | Client side carries 2 channels per frame |
| cfgWide | input | 1 | Audio samples are 32-bit (else 16-bit) |
| cfgMonoCopy | input | 1 | Mono-to-stereo copies the sample (else zero-fill) |
| cfgStereoSel | input | 2 | Stereo-to-mono pick: 0 first, 1 second, 2/3 average |
| cfgThresh | input | 7 | Requested threshold in frames |
| inValid | input | 1 | Audio word offered |
| inReady | output | 1 | FIFO can accept a word |
| inData | input | 32 | Audio word |
| outValid | output | 1 | Client frame available |
| outReady | input | 1 | Client accepts the frame |
| outLeft | output | 24 | Client channel 0 sample |
| outRight | output | 24 | Client channel 1 sample |
| threshHit | output | 1 | Buffered frames reached the clamped threshold |

## Verification
Every output is decoded combinationally from registered state. A word accepted at one rising edge is therefore visible in `outValid`, `outLeft`/`outRight`, `inReady` and `threshHit` in the same cycle, right after that edge, and a pop changes them in the same way. The bench changes inputs only at falling edges and samples outputs at the falling edge that follows each accepting rising edge, so each check sees the state exactly one edge after its stimulus. The sweep covers every combination of width, audio and client channel count, mono fill and stereo pick. Expected samples are computed arithmetically from the pushed words.

// File: rtl/acwc_pkg.sv
package acwc_pkg;

  typedef struct packed {
    logic push;     // store inData this cycle
    logic pop;      // release the head frame this cycle
    logic popTwo;   // head frame spans two words
  } acwcStrobe_t;

  typedef enum logic [1:0] {
    SEL_CH0 = 2'd0,
    SEL_CH1 = 2'd1,
    SEL_AVG = 2'd2
  } stereoSel_e;

endpackage

// File: rtl/acwc_ctrl.sv
module acwc_ctrl
  import acwc_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         cfgAudioStereo,
  input  logic [$clog2(DEPTH+1)-1:0]   cfgThresh,
  input  logic                         inValid,
  input  logic                         outReady,
  output logic                         inReady,
  output logic                         outValid,
  output logic                         threshHit,
  output logic [$clog2(DEPTH+1)-1:0]   fifoCount,
  output acwcStrobe_t                  strb
);
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [CNTW-1:0] frameWords;
  logic [CNTW-1:0] frames;
  logic [CNTW-1:0] maxThr;
  logic [CNTW-1:0] effThr;
  logic [CNTW-1:0] countNext;

  always_comb begin
    frameWords  = cfgAudioStereo ? CNTW'(2) : CNTW'(1);
    inReady     = (fifoCount != CNTW'(DEPTH));
    outValid    = (fifoCount >= frameWords);
    strb.push   = inValid && inReady;
    strb.pop    = outValid && outReady;
    strb.popTwo = cfgAudioStereo;
    countNext   = fifoCount + CNTW'(strb.push) - (strb.pop ? frameWords : '0);
    // threshold is in frames; its ceiling shrinks with the channel count
    frames      = cfgAudioStereo ? (fifoCount >> 1) : fifoCount;
    maxThr      = cfgAudioStereo ? CNTW'(DEPTH / 2 - 1) : CNTW'(DEPTH - 1);
    effThr      = (cfgThresh > maxThr) ? maxThr : cfgThresh;
    threshHit   = (frames >= effThr);
  end

  always_ff @(posedge clk) begin
    if (!rstN) fifoCount <= '0;
    else       fifoCount <= countNext;
  end

endmodule

// File: rtl/acwc_datapath.sv
module acwc_datapath
  import acwc_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = 32,
  parameter int CW    = 24,
  parameter int NW    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  acwcStrobe_t       strb,
  input  logic [AW-1:0]     inData,
  input  logic              cfgAudioStereo,
  input  logic              cfgClientStereo,
  input  logic              cfgWide,
  input  logic              cfgMonoCopy,
  input  logic [1:0]        cfgStereoSel,
  output logic [CW-1:0]     outLeft,
  output logic [CW-1:0]     outRight
);
  localparam int PTRW = $clog2(DEPTH);

  logic [AW-1:0]   mem [DEPTH];
  logic [PTRW-1:0] wrPtr;
  logic [PTRW-1:0] rdPtr;
  logic [AW-1:0]   word0;
  logic [AW-1:0]   word1;
  logic [CW-1:0]   samp0;
  logic [CW-1:0]   samp1;
  logic [CW:0]     pairSum;
  logic [CW-1:0]   pairAvg;

  function automatic logic [CW-1:0] widen(input logic [AW-1:0] w, input logic wide);
    if (wide) return w[AW-1:AW-CW];
    else      return {{(CW-NW){w[NW-1]}}, w[NW-1:0]};
  endfunction

  always_ff @(posedge clk) begin
    if (strb.push) mem[wrPtr] <= inData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strb.push) wrPtr <= wrPtr + PTRW'(1);
      if (strb.pop)  rdPtr <= rdPtr + (strb.popTwo ? PTRW'(2) : PTRW'(1));
    end
  end

  always_comb begin
    word0   = mem[rdPtr];
    word1   = mem[rdPtr + PTRW'(1)];
    samp0   = widen(word0, cfgWide);
    samp1   = widen(word1, cfgWide);
    pairSum = {samp0[CW-1], samp0} + {samp1[CW-1], samp1};
    pairAvg = pairSum[CW:1];   // floor division by two
    outLeft  = samp0;
    outRight = '0;
    if (!cfgAudioStereo) begin
      if (cfgClientStereo && cfgMonoCopy) outRight = samp0;
    end else if (cfgClientStereo) begin
      outRight = samp1;
    end else begin
      case (cfgStereoSel)
        SEL_CH0: outLeft = samp0;
        SEL_CH1: outLeft = samp1;
        default: outLeft = pairAvg;
      endcase
    end
  end

endmodule

// File: rtl/audio_chan_width_conv.sv
module audio_chan_width_conv
  import acwc_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = 32,
  parameter int CW    = 24,
  parameter int NW    = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cfgAudioStereo,
  input  logic                       cfgClientStereo,
  input  logic                       cfgWide,
  input  logic                       cfgMonoCopy,
  input  logic [1:0]                 cfgStereoSel,
  input  logic [$clog2(DEPTH+1)-1:0] cfgThresh,
  input  logic                       inValid,
  output logic                       inReady,
  input  logic [AW-1:0]              inData,
  output logic                       outValid,
  input  logic                       outReady,
  output logic [CW-1:0]              outLeft,
  output logic [CW-1:0]              outRight,
  output logic                       threshHit
);
  localparam int CNTW = $clog2(DEPTH + 1);

  acwcStrobe_t     strb;
  logic [CNTW-1:0] fifoCount;

  acwc_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgAudioStereo(cfgAudioStereo),
    .cfgThresh(cfgThresh), .inValid(inValid), .outReady(outReady),
    .inReady(inReady), .outValid(outValid), .threshHit(threshHit),
    .fifoCount(fifoCount), .strb(strb)
  );

  acwc_datapath #(.DEPTH(DEPTH), .AW(AW), .CW(CW), .NW(NW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .inData(inData),
    .cfgAudioStereo(cfgAudioStereo), .cfgClientStereo(cfgClientStereo),
    .cfgWide(cfgWide), .cfgMonoCopy(cfgMonoCopy), .cfgStereoSel(cfgStereoSel),
    .outLeft(outLeft), .outRight(outRight)
  );

endmodule

// File: rtl/acwc_checker.sv
module acwc_checker #(
  parameter int DEPTH = 64,
  parameter int CW    = 24
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       cfgAudioStereo,
  input logic                       cfgClientStereo,
  input logic                       cfgMonoCopy,
  input logic [$clog2(DEPTH+1)-1:0] cfgThresh,
  input logic                       inValid,
  input logic                       inReady,
  input logic                       outValid,
  input logic                       outReady,
  input logic [CW-1:0]              outLeft,
  input logic [CW-1:0]              outRight,
  input logic                       threshHit,
  input logic [$clog2(DEPTH+1)-1:0] fifoCount
);

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= ($clog2(DEPTH+1))'(DEPTH));

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rstN)
    (fifoCount == ($clog2(DEPTH+1))'(DEPTH)) |-> !inReady);

  p_push_only_r3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && !(outValid && outReady)) |=> (fifoCount == $past(fifoCount) + 1'b1));

  p_whole_frame_r3: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (fifoCount >= (cfgAudioStereo ? 2 : 1)));

  p_mono_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !cfgAudioStereo && cfgClientStereo && !cfgMonoCopy) |-> (outRight == '0));

  p_mono_copy_r5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !cfgAudioStereo && cfgClientStereo && cfgMonoCopy) |-> (outRight == outLeft));

  p_client_mono_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !cfgClientStereo) |-> (outRight == '0));

  p_thresh_empty_r8: assert property (@(posedge clk) disable iff (!rstN)
    (fifoCount == '0 && cfgThresh != '0) |-> !threshHit);

endmodule

bind audio_chan_width_conv acwc_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rstN(rstN), .cfgAudioStereo(cfgAudioStereo),
  .cfgClientStereo(cfgClientStereo), .cfgMonoCopy(cfgMonoCopy),
  .cfgThresh(cfgThresh), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outReady(outReady), .outLeft(outLeft),
  .outRight(outRight), .threshHit(threshHit), .fifoCount(fifoCount)
);

// File: tb/audio_chan_width_conv_tb.sv
module audio_chan_width_conv_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgAudioStereo = 1'b0;
  logic        cfgClientStereo = 1'b0;
  logic        cfgWide = 1'b0;
  logic        cfgMonoCopy = 1'b0;
  logic [1:0]  cfgStereoSel = 2'd0;
  logic [6:0]  cfgThresh = 7'd0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [31:0] inData = '0;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [23:0] outLeft;
  logic [23:0] outRight;
  logic        threshHit;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [31:0] words [64];

  always #4 clk = ~clk;   // 125 MHz

  audio_chan_width_conv u_dut (
    .clk(clk), .rstN(rstN), .cfgAudioStereo(cfgAudioStereo),
    .cfgClientStereo(cfgClientStereo), .cfgWide(cfgWide),
    .cfgMonoCopy(cfgMonoCopy), .cfgStereoSel(cfgStereoSel),
    .cfgThresh(cfgThresh), .inValid(inValid), .inReady(inReady),
    .inData(inData), .outValid(outValid), .outReady(outReady),
    .outLeft(outLeft), .outRight(outRight), .threshHit(threshHit)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] conv(input logic [31:0] w, input logic wide);
    return wide ? w[31:8] : {{8{w[15]}}, w[15:0]};
  endfunction

  function automatic logic [23:0] avg(input logic [23:0] a, input logic [23:0] b);
    logic [24:0] s;
    s = {a[23], a} + {b[23], b};
    return s[24:1];
  endfunction

  function automatic logic [31:0] pat(input int k);
    return (32'h9E3779B9 * 32'(k + 1)) ^ (32'(k) << 20);
  endfunction

  // called at a falling edge; returns at the next falling edge
  task automatic pushWord(input logic [31:0] w);
    inValid = 1'b1;
    inData  = w;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic popCheck(input string req, input logic [23:0] expL, input logic [23:0] expR);
    chk({req, " outValid"}, 32'(outValid), 32'd1);
    chk({req, " left"}, 32'(outLeft), 32'(expL));
    chk({req, " right"}, 32'(outRight), 32'(expR));
    outReady = 1'b1;
    @(negedge clk);
    outReady = 1'b0;
  endtask

  task automatic expectFrame(input string req, input logic [31:0] w0, input logic [31:0] w1);
    logic [23:0] s0, s1, eL, eR;
    s0 = conv(w0, cfgWide);
    s1 = conv(w1, cfgWide);
    eL = s0;
    eR = '0;
    if (!cfgAudioStereo) begin
      if (cfgClientStereo && cfgMonoCopy) eR = s0;
    end else if (cfgClientStereo) begin
      eR = s1;
    end else begin
      eL = (cfgStereoSel == 2'd0) ? s0 : (cfgStereoSel == 2'd1) ? s1 : avg(s0, s1);
    end
    popCheck(req, eL, eR);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    cfgThresh = 7'd3;
    @(negedge clk);
    // R1 reset state
    chk("R1 inReady", 32'(inReady), 32'd1);
    chk("R1 outValid", 32'(outValid), 32'd0);
    chk("R8 empty below threshold", 32'(threshHit), 32'd0);

    // sweep every mode: R4 R5 R6 R7 R9
    for (int wi = 0; wi < 2; wi++)
      for (int as = 0; as < 2; as++)
        for (int cs = 0; cs < 2; cs++)
          for (int mc = 0; mc < 2; mc++)
            for (int sl = 0; sl < 4; sl++) begin
              cfgWide = wi[0]; cfgAudioStereo = as[0]; cfgClientStereo = cs[0];
              cfgMonoCopy = mc[0]; cfgStereoSel = sl[1:0];
              for (int f = 0; f < 6; f++) begin
                words[f] = pat(seed + f);
                pushWord(words[f]);
              end
              seed += 6;
              if (as == 1) begin
                for (int f = 0; f < 3; f++)
                  expectFrame("R6/R7/R4/R9 stereo audio", words[2*f], words[2*f+1]);
              end else begin
                for (int f = 0; f < 6; f++)
                  expectFrame("R5/R7/R4/R9 mono audio", words[f], 32'd0);
              end
              chk("R3 drained", 32'(outValid), 32'd0);
            end

    // R6 average corner cases
    cfgAudioStereo = 1'b1; cfgClientStereo = 1'b0; cfgStereoSel = 2'd2;
    cfgWide = 1'b0;
    pushWord(32'h0000_8000); pushWord(32'h0000_7FFF);
    popCheck("R6 avg floor negative", 24'hFFFFFF, 24'h0);
    cfgWide = 1'b1;
    pushWord(32'h7FFF_FF00); pushWord(32'h7FFF_FF00);
    popCheck("R6 avg max no overflow", 24'h7FFFFF, 24'h0);
    pushWord(32'h8000_0000); pushWord(32'h8000_0100);
    popCheck("R6 avg min", 24'h800000, 24'h0);

    // R3 simultaneous push and pop, mono pass
    cfgAudioStereo = 1'b0; cfgClientStereo = 1'b0; cfgWide = 1'b0;
    pushWord(32'h0000_1234);
    inValid = 1'b1; inData = 32'h0000_ABCD; outReady = 1'b1;
    @(negedge clk);
    inValid = 1'b0; outReady = 1'b0;
    chk("R3 push+pop keeps one frame", 32'(outValid), 32'd1);
    popCheck("R3 head after push+pop", 24'hFFABCD, 24'h0);
    chk("R3 empty after push+pop", 32'(outValid), 32'd0);

    // R8 stereo clamp to 31, R2 full and dropped word
    cfgAudioStereo = 1'b1; cfgClientStereo = 1'b1; cfgWide = 1'b1; cfgThresh = 7'd100;
    for (int i = 0; i < 60; i++) begin
      words[i] = pat(1000 + i);
      pushWord(words[i]);
    end
    chk("R8 stereo 30 frames below clamp", 32'(threshHit), 32'd0);
    for (int i = 60; i < 62; i++) begin words[i] = pat(1000 + i); pushWord(words[i]); end
    chk("R8 stereo 31 frames hits clamp", 32'(threshHit), 32'd1);
    chk("R2 not full at 62", 32'(inReady), 32'd1);
    for (int i = 62; i < 64; i++) begin words[i] = pat(1000 + i); pushWord(words[i]); end
    chk("R2 full at 64", 32'(inReady), 32'd0);
    pushWord(32'hDEAD_BEEF);
    chk("R2 still full after dropped word", 32'(inReady), 32'd0);
    for (int f = 0; f < 32; f++)
      expectFrame("R9/R7 stereo drain", words[2*f], words[2*f+1]);
    chk("R2 dropped word absent", 32'(outValid), 32'd0);

    // R8 mono clamp to 63
    cfgAudioStereo = 1'b0; cfgClientStereo = 1'b0; cfgWide = 1'b0; cfgThresh = 7'd127;
    for (int i = 0; i < 62; i++) begin words[i] = pat(2000 + i); pushWord(words[i]); end
    chk("R8 mono 62 frames below clamp", 32'(threshHit), 32'd0);
    words[62] = pat(2062); pushWord(words[62]);
    chk("R8 mono 63 frames hits clamp", 32'(threshHit), 32'd1);
    cfgThresh = 7'd5;
    chk("R8 low threshold exceeded", 32'(threshHit), 32'd1);
    for (int f = 0; f < 59; f++)
      expectFrame("R7/R9 mono drain", words[f], 32'd0);
    chk("R8 four frames below five", 32'(threshHit), 32'd0);
    for (int f = 59; f < 63; f++)
      expectFrame("R7/R9 mono drain tail", words[f], 32'd0);
    chk("R3 empty at end", 32'(outValid), 32'd0);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule